// File: doc/BRIEF.md
# Shared Parallel I/O Port with Peripheral Override

This block is a parallel I/O port of up to sixteen pins that sits behind a simple register bus. Software sees three registers. The direction register decides, pin by pin, whether the port drives the pad. The output latch holds the value the port drives. The pin register reports the synchronised level on each pad. Reading the latch returns what was stored. Reading the pin register returns what is on the wire. A write through either the latch or the pin register updates the latch.

Each pin also has a peripheral that can take over the pad. When that pin's peripheral is enabled and is actively driving, a two-way mux passes the peripheral's data and output enable to the pad instead of the port's. In every other case the port's latch and direction bits control the pad. The pad level stays readable through the pin register whichever side owns the output.

A parameter mask marks which pins exist. Bits outside the mask read as zero in all three registers, ignore writes, and never drive their pads. Pad inputs pass through a two-flop synchroniser before they reach the read path.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset, every implemented direction bit reads 1 (input), every latch bit reads 0, and pad_oe is 0 on all pins.
- R2: A direction bit of 0 makes a port-owned pin an output: pad_oe is 1 and pad_out equals that pin's latch bit. A direction bit of 1 gives pad_oe 0.
- R3: A read with sel_lat returns the stored latch value, independent of the pad levels.
- R4: A write with sel_port updates the latch; a later read with sel_lat returns the written value.
- R5: A read with sel_port returns the pad level seen through a two-flop synchroniser. A change at pad_in is first visible after the second rising clock edge.
- R6: When per_en and per_drv are both 1 for a pin, pad_out and pad_oe for that pin follow per_out and per_oe.
- R7: When either per_en or per_drv is 0 for a pin, that pin's pad_out and pad_oe come from the latch and the direction bit, even if per_out and per_oe are set.
- R8: While a peripheral owns a pin, a read with sel_port still returns that pin's synchronised pad level.
- R9: Pins outside IMPL_MASK read as 0 through sel_dir, sel_lat and sel_port, ignore writes, and hold pad_oe and pad_out at 0.
- R10: A write (reg_wr with one select high) changes the register on the next rising edge, and rdata shows the old value until then. Reads are combinational. At most one of sel_dir, sel_lat and sel_port is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| reg_wr | input | 1 | Write strobe for the selected register |
| sel_dir | input | 1 | Selects the direction register |
| sel_lat | input | 1 | Selects the output latch |
| sel_port | input | 1 | Selects the pin register (read pads, write latch) |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data from the selected register, 0 when none is selected |
| per_en | input | NPINS | Peripheral enabled, per pin |
| per_drv | input | NPINS | Peripheral actively driving, per pin |
| per_out | input | NPINS | Peripheral output data, per pin |
| per_oe | input | NPINS | Peripheral output enable, active high, per pin |
| pad_out | output | NPINS | Data to the pad driver |
| pad_oe | output | NPINS | Pad output enable, active high |
| pad_in | input | NPINS | Level sampled at the pad |

## Verification
The ownership mux is tried with one pattern that mixes four kinds of pin. Some pins are enabled and driving, some are enabled but idle, some drive without being enabled, and some are untouched. Only the first kind may hand the pad to the peripheral, so this one pattern separates an AND of the two qualifiers from an OR of them or from either one alone. Latch and pad values are chosen to differ, which shows whether a read comes from the latch or from the pins. A single pad change is sampled after one edge and after two, which pins the synchroniser depth. The unimplemented high pins are written with all ones and driven high at the pad, so any leak through the mask shows up in a read or on the pad outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_LAT  = 2'd2,
    RSEL_PIN  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned          NPINS     = 16,
  parameter logic [NPINS-1:0]     IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             lat_we,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lat_q
);

  logic [NPINS-1:0] dir_d;
  logic [NPINS-1:0] lat_d;

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (dir_we) dir_d = wdata & IMPL_MASK;
    if (lat_we) lat_d = wdata & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= IMPL_MASK;
      lat_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_d;
      if (lat_we) lat_q <= lat_d;
    end
  end

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> lat_q == ($past(wdata) & IMPL_MASK)); // R4

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> dir_q == ($past(wdata) & IMPL_MASK)); // R2

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q)); // R10

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign pin_sync = sync_q;

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> meta_q == $past(pad_in)); // R5

  AST_SYNC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_q == $past(meta_q)); // R5

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter bit IMPLEMENTED = 1'b1
) (
  input  logic per_en,
  input  logic per_drv,
  input  logic per_out,
  input  logic per_oe,
  input  logic lat_bit,
  input  logic dir_bit,
  output logic pad_out,
  output logic pad_oe
);

  logic periph_owns;

  always_comb begin
    periph_owns = per_en & per_drv;
    if (periph_owns) begin
      pad_out = IMPLEMENTED & per_out;
      pad_oe  = IMPLEMENTED & per_oe;
    end else begin
      pad_out = IMPLEMENTED & lat_bit;
      pad_oe  = IMPLEMENTED & ~dir_bit;
    end
  end

endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned      NPINS     = 16,
  parameter logic [NPINS-1:0] IMPL_MASK = 16'h3FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             sel_dir,
  input  logic             sel_lat,
  input  logic             sel_port,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] per_en,
  input  logic [NPINS-1:0] per_drv,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] pad_in
);

  reg_sel_e         rsel;
  logic             dir_we;
  logic             lat_we;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] pin_sync;

  always_comb begin
    if (sel_dir)       rsel = RSEL_DIR;
    else if (sel_lat)  rsel = RSEL_LAT;
    else if (sel_port) rsel = RSEL_PIN;
    else               rsel = RSEL_NONE;
  end

  assign dir_we = reg_wr & (rsel == RSEL_DIR);
  assign lat_we = reg_wr & ((rsel == RSEL_LAT) | (rsel == RSEL_PIN));

  gpio_port_regs #(
    .NPINS     (NPINS),
    .IMPL_MASK (IMPL_MASK)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (dir_we),
    .lat_we (lat_we),
    .wdata  (wdata),
    .dir_q  (dir_q),
    .lat_q  (lat_q)
  );

  gpio_in_sync #(
    .NPINS (NPINS)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  always_comb begin
    unique case (rsel)
      RSEL_DIR: rdata = dir_q;
      RSEL_LAT: rdata = lat_q;
      RSEL_PIN: rdata = pin_sync & IMPL_MASK;
      default:  rdata = '0;
    endcase
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pad_mux #(
      .IMPLEMENTED (IMPL_MASK[p])
    ) u_mux (
      .per_en  (per_en[p]),
      .per_drv (per_drv[p]),
      .per_out (per_out[p]),
      .per_oe  (per_oe[p]),
      .lat_bit (lat_q[p]),
      .dir_bit (dir_q[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p])
    );
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_dir, sel_lat, sel_port})); // R10

  AST_RD_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~IMPL_MASK) == '0); // R9

  AST_PAD_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~IMPL_MASK) == '0); // R9

  AST_PORT_OWNED_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~(per_en & per_drv)) & IMPL_MASK & pad_oe) == (IMPL_MASK & ~(per_en & per_drv) & ~dir_q)); // R7

endmodule

// File: tb/gpio_shared_port_bench.sv
module gpio_shared_port_bench;

  localparam int unsigned      N    = 16;
  localparam logic [N-1:0]     MASK = 16'h3FFF;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, sel_dir, sel_lat, sel_port;
  logic [N-1:0] wdata, rdata;
  logic [N-1:0] per_en, per_drv, per_out, per_oe;
  logic [N-1:0] pad_out, pad_oe, pad_in;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpio_shared_port #(.NPINS(N), .IMPL_MASK(MASK)) u_gpio_shared_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .sel_dir(sel_dir), .sel_lat(sel_lat), .sel_port(sel_port),
    .wdata(wdata), .rdata(rdata),
    .per_en(per_en), .per_drv(per_drv), .per_out(per_out), .per_oe(per_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    reg_wr = 0; sel_dir = 0; sel_lat = 0; sel_port = 0; wdata = '0;
  endtask

  // which: 1 dir, 2 latch, 3 pin register
  task automatic wr(input int which, input logic [N-1:0] d);
    @(negedge clk);
    idle_bus();
    reg_wr = 1; wdata = d;
    sel_dir = (which == 1); sel_lat = (which == 2); sel_port = (which == 3);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic rd(input int which, output logic [N-1:0] d);
    @(negedge clk);
    idle_bus();
    sel_dir = (which == 1); sel_lat = (which == 2); sel_port = (which == 3);
    #1 d = rdata;
    idle_bus();
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(1, v); check("R1 dir after reset", v, MASK);
    rd(2, v); check("R1 latch after reset", v, '0);
    check("R1 pad_oe after reset", pad_oe, '0);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    reg_wr = 1; sel_lat = 1; wdata = 16'h0123;
    #1 check("R10 old value before edge", rdata, '0);
    @(negedge clk);
    reg_wr = 0;
    #1 check("R10 new value after edge", rdata, 16'h0123);
    idle_bus();
  endtask

  task automatic t_latch_vs_pin();
    logic [N-1:0] v;
    wr(2, 16'hA5A5);
    pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(2, v); check("R3 latch read ignores pads", v, 16'h25A5);
    rd(3, v); check("R5 pin read shows pads", v, 16'h1234);
  endtask

  task automatic t_pin_write();
    logic [N-1:0] v;
    wr(3, 16'h0F0F);
    rd(2, v); check("R4 pin write lands in latch", v, 16'h0F0F);
    rd(3, v); check("R4 pin read still shows pads", v, 16'h1234);
  endtask

  task automatic t_direction();
    wr(1, 16'h00FF);
    #1;
    check("R2 pad_oe from direction", pad_oe, 16'h3F00);
    check("R2 pad_out from latch", pad_out & pad_oe, 16'h0F00);
  endtask

  task automatic t_periph();
    logic [N-1:0] v;
    wr(1, 16'h0000);
    wr(2, 16'hFFF0);
    @(negedge clk);
    per_en = 16'h00FF; per_drv = 16'h0F0F; per_out = 16'h0F05; per_oe = 16'h0F03;
    #1;
    check("R6 R7 pad_out ownership", pad_out, 16'h3FF5);
    check("R6 R7 pad_oe ownership", pad_oe, 16'h3FF3);
    pad_in = 16'h0009;
    repeat (2) @(negedge clk);
    rd(3, v); check("R8 pin readable under peripheral", v, 16'h0009);
    per_en = '0; per_drv = '0; per_out = '0; per_oe = '0;
    #1 check("R7 port regains pads", pad_out, 16'h3FF0);
  endtask

  task automatic t_sync_latency();
    @(negedge clk);
    pad_in = 16'h1111; sel_port = 1;
    @(negedge clk); #1 check("R5 one edge still old", rdata, 16'h0009);
    @(negedge clk); #1 check("R5 two edges shows new", rdata, 16'h1111);
    idle_bus();
  endtask

  task automatic t_unimpl();
    logic [N-1:0] v;
    wr(1, 16'hFFFF);
    rd(1, v); check("R9 dir high bits zero", v, 16'h3FFF);
    wr(2, 16'hC000);
    rd(2, v); check("R9 latch high bits zero", v, 16'h0000);
    pad_in = 16'hC000;
    repeat (3) @(negedge clk);
    rd(3, v); check("R9 pin high bits zero", v, 16'h0000);
    wr(2, 16'hFFFF);
    wr(1, 16'h0000);
    #1;
    check("R9 pad_oe unimplemented", pad_oe & ~MASK, '0);
    check("R9 pad_out unimplemented", pad_out & ~MASK, '0);
    check("R2 all outputs enabled", pad_oe, MASK);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_bus();
    per_en = '0; per_drv = '0; per_out = '0; per_oe = '0;
    pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_timing();
    t_latch_vs_pin();
    t_pin_write();
    t_direction();
    t_periph();
    t_sync_latency();
    t_unimpl();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule